// File: doc/BRIEF.md
# Two-Level Bounds Entry Walker

This block finds the bounds record that belongs to a pointer kept in memory and then reads or writes that record. The search uses the address where the pointer is stored, not the pointer value. It takes two steps, in the manner of a page walk. No MMU takes part and no translation cache holds earlier results, so every walk sends its accesses to ordinary memory. In the first step, an upper slice of the storage address picks a slot in a directory. The directory base comes from one of two configuration registers, and the privilege flag decides which one. In the second step, the directory slot, with its flag bits removed, gives the base of a table. A lower slice of the storage address then picks a 32-byte record in that table.

A read walk returns the lower and upper bounds from the record. The record also holds a copy of the pointer. When that copy differs from the pointer supplied with the request, the walker returns always-true bounds. It does the same when the directory slot is empty. A write walk puts the bounds and the pointer copy into the record. If the directory slot is empty, a write walk instead raises a fault and writes nothing, so that software can install a table and issue the request again. The walker handles one request at a time and drives a 64-bit memory port with at most one access outstanding.

Top module: `bt_walker`

## Requirements
- R1: In user mode (`req_kernel`=0), the first memory access of a walk is a read of the directory slot at `cfg_user_base + (slot_addr[47:20] << 3)`.
- R2: In kernel mode (`req_kernel`=1), the directory slot is read at `cfg_super_base + (slot_addr[47:20] << 3)`.
- R3: A directory slot is valid when bit 0 is 1. The table base is the slot value with bits 2:0 cleared. The record sits at table base `+ (slot_addr[19:3] << 5)`, and word k of the record is at record `+ 8*k`.
- R4: A read walk with a valid directory slot reads record words 0 (lower bound), 1 (upper bound) and 2 (pointer copy) in that order. When the pointer copy equals `req_ptr`, the walk returns the stored bounds with `rsp_init`=0.
- R5: When the pointer copy differs from `req_ptr`, a read walk returns always-true bounds: `rsp_lb`=0, `rsp_ub`=all ones, `rsp_init`=1.
- R6: A read walk whose directory slot is invalid makes no table access and raises no fault. It completes with always-true bounds and `rsp_init`=1.
- R7: A write walk whose directory slot is invalid pulses `fault` and issues no memory write.
- R8: A write walk with a valid directory slot writes `req_lb`, `req_ub` and `req_ptr` to record words 0, 1 and 2, then pulses `done`.
- R9: A write walk that faulted completes normally when it is issued again after a valid directory slot has been installed.
- R10: A request is taken only while `ready` is 1. `ready` is 1 only when the walker is idle, and `req_valid` has no effect while `ready` is 0.
- R11: `done` and `fault` are single-cycle pulses and are never high in the same cycle.
- R12: Once `mem_req` is raised, it stays high with the same address, write flag and write data until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_store | input | 1 | 1 = write walk, 0 = read walk |
| req_kernel | input | 1 | Privilege flag; selects the directory base |
| req_slot_addr | input | 64 | Address where the pointer is stored |
| req_ptr | input | 64 | Pointer value |
| req_lb | input | 64 | Lower bound to write |
| req_ub | input | 64 | Upper bound to write |
| cfg_user_base | input | 64 | Directory base for user mode |
| cfg_super_base | input | 64 | Directory base for kernel mode |
| ready | output | 1 | Walker idle, request may be presented |
| done | output | 1 | Walk complete (one cycle) |
| fault | output | 1 | Write walk found an invalid directory slot (one cycle) |
| rsp_lb | output | 64 | Returned lower bound, valid with `done` on a read walk |
| rsp_ub | output | 64 | Returned upper bound, valid with `done` on a read walk |
| rsp_init | output | 1 | Always-true bounds were returned |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory access accepted/completed |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |

## Verification
The assertions assume that the memory port acknowledges only while `mem_req` is high, and that read data is valid in the same cycle as the acknowledge. The bench's memory model raises `mem_ack` one cycle after it sees a request and drops it right after, so every access is accepted exactly once and each request is held for one full cycle. The bench raises `req_valid` for a single cycle when `ready` is high. The one exception is a deliberate strobe during a busy walk, sent to show that such a strobe is ignored.

// File: rtl/bt_walker_pkg.sv
package bt_walker_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_RD,
        ST_WR,
        ST_DONE,
        ST_FAULT
    } walk_st_e;
endpackage

// File: rtl/bt_addr_gen.sv
module bt_addr_gen #(
    parameter int AW      = 64,
    parameter int DIR_LSB = 20,
    parameter int DIR_MSB = 47,
    parameter int TBL_LSB = 3,
    parameter int DIR_SH  = 3,
    parameter int REC_SH  = 5,
    parameter int WIDX_W  = 2
) (
    input  logic [AW-1:0]     dir_base,
    input  logic [AW-1:0]     slot_addr,
    input  logic [AW-1:0]     dir_entry,
    input  logic [WIDX_W-1:0] widx,
    output logic [AW-1:0]     dir_addr,
    output logic [AW-1:0]     word_addr
);
    localparam int DIR_BITS = DIR_MSB - DIR_LSB + 1;
    localparam int TBL_BITS = DIR_LSB - TBL_LSB;

    logic [AW-1:0] dir_off, rec_off, tbl_base, word_off;

    always_comb begin
        dir_off   = AW'({slot_addr[DIR_MSB:DIR_LSB], {DIR_SH{1'b0}}});
        rec_off   = AW'({slot_addr[DIR_LSB-1:TBL_LSB], {REC_SH{1'b0}}});
        tbl_base  = {dir_entry[AW-1:DIR_SH], {DIR_SH{1'b0}}};
        word_off  = AW'({widx, 3'b000});
        dir_addr  = dir_base + dir_off;
        word_addr = tbl_base + rec_off + word_off;
    end

    if (DIR_BITS + DIR_SH > AW || TBL_BITS + REC_SH > AW) begin : g_bad_cfg
        initial $error("bt_addr_gen: index slices too wide");
    end
endmodule

// File: rtl/bt_entry_sel.sv
module bt_entry_sel #(
    parameter int DW = 64
) (
    input  logic          dir_ok,
    input  logic [DW-1:0] rec_lb,
    input  logic [DW-1:0] rec_ub,
    input  logic [DW-1:0] rec_ptr,
    input  logic [DW-1:0] req_ptr,
    output logic [DW-1:0] out_lb,
    output logic [DW-1:0] out_ub,
    output logic          out_init
);
    always_comb begin
        out_init = !dir_ok || (rec_ptr != req_ptr);
        out_lb   = out_init ? '0 : rec_lb;
        out_ub   = out_init ? '1 : rec_ub;
    end
endmodule

// File: rtl/bt_walker.sv
module bt_walker
    import bt_walker_pkg::*;
#(
    parameter int AW      = 64,
    parameter int DW      = 64,
    parameter int DIR_LSB = 20,
    parameter int DIR_MSB = 47,
    parameter int TBL_LSB = 3,
    parameter int NWORDS  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_store,
    input  logic          req_kernel,
    input  logic [AW-1:0] req_slot_addr,
    input  logic [DW-1:0] req_ptr,
    input  logic [DW-1:0] req_lb,
    input  logic [DW-1:0] req_ub,
    input  logic [AW-1:0] cfg_user_base,
    input  logic [AW-1:0] cfg_super_base,
    output logic          ready,
    output logic          done,
    output logic          fault,
    output logic [DW-1:0] rsp_lb,
    output logic [DW-1:0] rsp_ub,
    output logic          rsp_init,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam int WIDX_W = $clog2(NWORDS + 1);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(NWORDS - 1);

    typedef struct packed {
        walk_st_e          st;
        logic              is_store;
        logic [AW-1:0]     slot;
        logic [DW-1:0]     ptr;
        logic [DW-1:0]     lb;
        logic [DW-1:0]     ub;
        logic [AW-1:0]     base;
        logic [AW-1:0]     dent;
        logic              dir_ok;
        logic [WIDX_W-1:0] widx;
        logic [DW-1:0]     r_lb;
        logic [DW-1:0]     r_ub;
        logic [DW-1:0]     r_ptr;
    } walk_s;

    walk_s s_d, s_q;
    logic [AW-1:0] dir_addr, word_addr;

    bt_addr_gen #(
        .AW(AW), .DIR_LSB(DIR_LSB), .DIR_MSB(DIR_MSB),
        .TBL_LSB(TBL_LSB), .DIR_SH(3), .REC_SH(5), .WIDX_W(WIDX_W)
    ) addr_i (
        .dir_base (s_q.base),
        .slot_addr(s_q.slot),
        .dir_entry(s_q.dent),
        .widx     (s_q.widx),
        .dir_addr (dir_addr),
        .word_addr(word_addr)
    );

    bt_entry_sel #(.DW(DW)) sel_i (
        .dir_ok  (s_q.dir_ok),
        .rec_lb  (s_q.r_lb),
        .rec_ub  (s_q.r_ub),
        .rec_ptr (s_q.r_ptr),
        .req_ptr (s_q.ptr),
        .out_lb  (rsp_lb),
        .out_ub  (rsp_ub),
        .out_init(rsp_init)
    );

    always_comb begin
        s_d       = s_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st       = ST_DIR;
                    s_d.is_store = req_store;
                    s_d.slot     = req_slot_addr;
                    s_d.ptr      = req_ptr;
                    s_d.lb       = req_lb;
                    s_d.ub       = req_ub;
                    s_d.base     = req_kernel ? cfg_super_base : cfg_user_base;
                    s_d.widx     = '0;
                    s_d.dir_ok   = 1'b0;
                end
            end
            ST_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
                if (mem_ack) begin
                    s_d.dent   = AW'(mem_rdata);
                    s_d.dir_ok = mem_rdata[0];
                    if (!mem_rdata[0])
                        s_d.st = s_q.is_store ? ST_FAULT : ST_DONE;
                    else
                        s_d.st = s_q.is_store ? ST_WR : ST_RD;
                end
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = word_addr;
                if (mem_ack) begin
                    case (s_q.widx)
                        WIDX_W'(0): s_d.r_lb  = mem_rdata;
                        WIDX_W'(1): s_d.r_ub  = mem_rdata;
                        default:    s_d.r_ptr = mem_rdata;
                    endcase
                    s_d.widx = s_q.widx + 1'b1;
                    if (s_q.widx == LAST_W) s_d.st = ST_DONE;
                end
            end
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = word_addr;
                case (s_q.widx)
                    WIDX_W'(0): mem_wdata = s_q.lb;
                    WIDX_W'(1): mem_wdata = s_q.ub;
                    default:    mem_wdata = s_q.ptr;
                endcase
                if (mem_ack) begin
                    s_d.widx = s_q.widx + 1'b1;
                    if (s_q.widx == LAST_W) s_d.st = ST_DONE;
                end
            end
            ST_DONE:  s_d.st = ST_IDLE;
            ST_FAULT: s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready = (s_q.st == ST_IDLE);
    assign done  = (s_q.st == ST_DONE);
    assign fault = (s_q.st == ST_FAULT);
endmodule

// File: rtl/bt_walker_chk.sv
module bt_walker_chk #(
    parameter int AW = 64,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready,
    input logic          done,
    input logic          fault,
    input logic [DW-1:0] rsp_lb,
    input logic [DW-1:0] rsp_ub,
    input logic          rsp_init,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack
);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fault_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_init_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && rsp_init |-> rsp_lb == '0 && rsp_ub == '1);

    p_busy_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ready);

    p_fault_after_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(mem_req && !mem_we && mem_ack));
endmodule

bind bt_walker bt_walker_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .fault(fault),
    .rsp_lb(rsp_lb), .rsp_ub(rsp_ub), .rsp_init(rsp_init),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/bt_walker_tb_top.sv
module bt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_kernel = 1'b0;
    logic [63:0] req_slot_addr = '0, req_ptr = '0, req_lb = '0, req_ub = '0;
    logic [63:0] cfg_user_base = 64'h0000_0000_1000_0000;
    logic [63:0] cfg_super_base = 64'h0000_0000_2000_0000;
    logic        ready, done, fault, rsp_init, mem_req, mem_we;
    logic [63:0] rsp_lb, rsp_ub, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int errors = 0, checks = 0;
    logic [63:0] mem [logic [63:0]];
    int acc_cnt = 0, wr_cnt = 0, hold_err = 0;
    logic [63:0] first_addr = '0, pend_addr = '0;

    logic        r_done, r_fault, r_init;
    logic [63:0] r_lb, r_ub;
    int          pulse_len;

    localparam logic [63:0] SLOT_A = 64'h0000_1234_5678_9AB8;
    localparam logic [63:0] SLOT_B = 64'h0000_0ABC_DEF0_1230;
    localparam logic [63:0] TBASE  = 64'h0000_0000_4000_0000;

    always #10 clk = ~clk;

    bt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_kernel(req_kernel), .req_slot_addr(req_slot_addr), .req_ptr(req_ptr),
        .req_lb(req_lb), .req_ub(req_ub), .cfg_user_base(cfg_user_base),
        .cfg_super_base(cfg_super_base), .ready(ready), .done(done), .fault(fault),
        .rsp_lb(rsp_lb), .rsp_ub(rsp_ub), .rsp_init(rsp_init), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            pend_addr <= mem_addr;
            if (acc_cnt == 0) first_addr <= mem_addr;
            acc_cnt = acc_cnt + 1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
            end
        end else begin
            if (mem_ack && (!mem_req || mem_addr != pend_addr)) hold_err = hold_err + 1;
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [63:0] dir_of(input logic [63:0] base, input logic [63:0] slot);
        return base + {8'h0, slot[47:20], 3'b000};
    endfunction

    function automatic logic [63:0] rec_of(input logic [63:0] tb, input logic [63:0] slot);
        return {tb[63:3], 3'b000} + {42'h0, slot[19:3], 5'b00000};
    endfunction

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        acc_cnt = 0;
        wr_cnt = 0;
    endtask

    task automatic walk(input bit st, input bit kern, input logic [63:0] slot,
                        input logic [63:0] p, input logic [63:0] lb, input logic [63:0] ub);
        @(negedge clk);
        clear_log();
        req_valid = 1'b1; req_store = st; req_kernel = kern;
        req_slot_addr = slot; req_ptr = p; req_lb = lb; req_ub = ub;
        @(negedge clk);
        req_valid = 1'b0;
        r_done = 1'b0; r_fault = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done || fault) break;
            @(negedge clk);
        end
        r_done = done; r_fault = fault; r_init = rsp_init; r_lb = rsp_lb; r_ub = rsp_ub;
        pulse_len = 0;
        while ((done || fault) && pulse_len < 5) begin
            pulse_len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(ready === 1'b1, "R10 ready after reset", 64'(ready), 64'd1);
        chk(done === 1'b0 && fault === 1'b0, "R11 idle pulses", 64'({done, fault}), 64'd0);
        chk(mem_req === 1'b0, "R12 no access after reset", 64'(mem_req), 64'd0);
    endtask

    task automatic t_store_fault();
        walk(1'b1, 1'b0, SLOT_A, 64'hAAAA, 64'h100, 64'h1FF);
        chk(r_fault === 1'b1 && r_done === 1'b0, "R7 fault on invalid dir", 64'({r_fault, r_done}), 64'h2);
        chk(wr_cnt == 0, "R7 no write", 64'(wr_cnt), 64'd0);
        chk(first_addr == dir_of(cfg_user_base, SLOT_A), "R1 user dir address", first_addr,
            dir_of(cfg_user_base, SLOT_A));
        chk(pulse_len == 1, "R11 fault pulse width", 64'(pulse_len), 64'd1);
    endtask

    task automatic t_store_retry();
        logic [63:0] e;
        mem[dir_of(cfg_user_base, SLOT_A)] = TBASE | 64'h7;
        walk(1'b1, 1'b0, SLOT_A, 64'hAAAA, 64'h100, 64'h1FF);
        e = rec_of(TBASE, SLOT_A);
        chk(r_done === 1'b1 && r_fault === 1'b0, "R9 retry completes", 64'({r_done, r_fault}), 64'h2);
        chk(wr_cnt == 3, "R8 three writes", 64'(wr_cnt), 64'd3);
        chk(rd(e) == 64'h100, "R8 R3 word0 lower", rd(e), 64'h100);
        chk(rd(e + 8) == 64'h1FF, "R8 R3 word1 upper", rd(e + 8), 64'h1FF);
        chk(rd(e + 16) == 64'hAAAA, "R8 R3 word2 pointer", rd(e + 16), 64'hAAAA);
        chk(pulse_len == 1, "R11 done pulse width", 64'(pulse_len), 64'd1);
    endtask

    task automatic t_load_match();
        walk(1'b0, 1'b0, SLOT_A, 64'hAAAA, 64'h0, 64'h0);
        chk(r_done === 1'b1, "R4 load done", 64'(r_done), 64'd1);
        chk(acc_cnt == 4 && wr_cnt == 0, "R4 four reads", 64'(acc_cnt), 64'd4);
        chk(r_lb == 64'h100 && r_ub == 64'h1FF, "R4 stored bounds", r_ub, 64'h1FF);
        chk(r_init === 1'b0, "R4 not init", 64'(r_init), 64'd0);
    endtask

    task automatic t_load_mismatch();
        walk(1'b0, 1'b0, SLOT_A, 64'hBBBB, 64'h0, 64'h0);
        chk(r_init === 1'b1, "R5 init flag", 64'(r_init), 64'd1);
        chk(r_lb == 64'h0 && r_ub == '1, "R5 always-true bounds", r_ub, '1);
    endtask

    task automatic t_kernel_invalid();
        walk(1'b0, 1'b1, SLOT_A, 64'hAAAA, 64'h0, 64'h0);
        chk(first_addr == dir_of(cfg_super_base, SLOT_A), "R2 super dir address", first_addr,
            dir_of(cfg_super_base, SLOT_A));
        chk(r_done === 1'b1 && r_fault === 1'b0, "R6 no fault on load", 64'({r_done, r_fault}), 64'h2);
        chk(acc_cnt == 1, "R6 no table access", 64'(acc_cnt), 64'd1);
        chk(r_init === 1'b1 && r_ub == '1 && r_lb == 0, "R6 init bounds", r_ub, '1);
    endtask

    task automatic t_busy_ignore();
        logic [63:0] eb;
        mem[dir_of(cfg_user_base, SLOT_B)] = TBASE | 64'h1;
        eb = rec_of(TBASE, SLOT_B);
        @(negedge clk);
        clear_log();
        req_valid = 1'b1; req_store = 1'b0; req_kernel = 1'b0;
        req_slot_addr = SLOT_A; req_ptr = 64'hAAAA;
        @(negedge clk);
        chk(ready === 1'b0, "R10 busy after accept", 64'(ready), 64'd0);
        req_store = 1'b1; req_slot_addr = SLOT_B; req_ptr = 64'hCCCC;
        req_lb = 64'h5; req_ub = 64'h6;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done) break;
            @(negedge clk);
        end
        r_lb = rsp_lb;
        @(negedge clk);
        @(negedge clk);
        chk(r_lb == 64'h100, "R10 first request result", r_lb, 64'h100);
        chk(acc_cnt == 4 && wr_cnt == 0, "R10 strobe while busy ignored", 64'(wr_cnt), 64'd0);
        chk(rd(eb + 16) == 64'h0, "R10 no write to second record", rd(eb + 16), 64'h0);
        chk(ready === 1'b1, "R10 idle again", 64'(ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_fault();
        t_store_retry();
        t_load_match();
        t_load_mismatch();
        t_kernel_invalid();
        t_busy_ignore();
        chk(hold_err == 0, "R12 request held until ack", 64'(hold_err), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule